// File: doc/BRIEF.md
# Line Mode Detect and Interrupt Router

This block is the mode-control core of a caller-identity receiver. It reads two control pins, a power-down select and a mode select, and registers them into one of three operating modes: dual-tone alert detection, FSK reception, or zero-power. The mode decides where the detect output and the active-low interrupt output take their values from. It also decides whether the analog path and the oscillator are enabled, and which level threshold the analog comparator applies.

In FSK mode the block qualifies a raw comparator flag, which reports that the line level is above threshold, into a carrier-detect flag. It does this with time hysteresis. The flag sets only after the level has been high without a break for an on delay. It clears only after the level has been low without a break for a shorter off delay. Both delays are counted in milliseconds from a prescaled tick. Any break in the level restarts the pending delay. Any change of mode sends the qualifier back to its idle state.

The mode register has three states: MODE_TONE, MODE_FSK and MODE_ZPWR. On every clock it moves to the state decoded from the pins, and that move is the only transition it has. The carrier qualifier has four states:
- QUAL_IDLE: carrier off.
- QUAL_RISE: off, timing the on delay.
- QUAL_ON: carrier on.
- QUAL_FALL: on, timing the off delay.

Its transitions are:
- IDLE→RISE when the level is high.
- RISE→IDLE when the level drops.
- RISE→ON when the on delay expires.
- ON→FALL when the level is low.
- FALL→ON when the level returns.
- FALL→IDLE when the off delay expires.
- Any state→IDLE when the clear condition holds.

Top module: `line_mode_detect`

## Requirements
- R1: The mode register takes its value at each clock edge from the pins. zp_i=1 gives zero-power whatever mode_sel_i is. zp_i=0 with mode_sel_i=0 gives tone mode. zp_i=0 with mode_sel_i=1 gives FSK mode. Reset selects zero-power.
- R2: In tone mode, det_o equals tone_det_i. irq_no is low when tone_irq_ni is low, or when ring_wake_en_i and ring_det_i are both high.
- R3: In FSK mode, det_o equals the qualified carrier flag. irq_no is low when rt_irq_ni is low or ring_det_i is high.
- R4: In zero-power mode, det_o equals ring_det_i and irq_no equals the inverse of ring_det_i. The tone, retiming and level inputs have no effect.
- R5: analog_en_o and osc_en_o are 0 in zero-power mode and 1 in the other two modes.
- R6: thr_sel_o is 1 (FSK threshold) in FSK mode and 0 in the other modes.
- R7: In FSK mode the carrier flag rises at the edge that is ON_MS*TICK_DIV edges after the first edge that samples lvl_above_i high, provided the level stays high throughout.
- R8: The carrier flag falls at the edge that is OFF_MS*TICK_DIV edges after the first edge that samples lvl_above_i low, provided the level stays low throughout.
- R9: A break in the level during a pending delay restarts that delay. A short high pulse leaves the flag at 0, and a short low dip leaves it at 1.
- R10: On a change of the mode register, the carrier flag is 0 in the same cycle. After a return to FSK mode it needs a full on delay again.
- R11: The carrier flag is 0 whenever the mode is not FSK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| zp_i | input | 1 | Zero-power select |
| mode_sel_i | input | 1 | 0 selects tone mode, 1 selects FSK mode |
| lvl_above_i | input | 1 | Comparator flag: line level above threshold |
| ring_det_i | input | 1 | Ring or polarity-reversal detected |
| ring_wake_en_i | input | 1 | Allows ring detection to interrupt in tone mode |
| tone_det_i | input | 1 | Tone detector output |
| tone_irq_ni | input | 1 | Active-low qualified-tone interrupt request |
| rt_irq_ni | input | 1 | Active-low retiming interrupt request |
| det_o | output | 1 | Routed detect output |
| irq_no | output | 1 | Routed active-low interrupt (AND of the selected requests) |
| analog_en_o | output | 1 | Enable for the analog path |
| osc_en_o | output | 1 | Enable for the oscillator |
| thr_sel_o | output | 1 | Comparator threshold select (1 = FSK) |

## Verification
A change on the mode pins reaches the routing and the enables one edge later, because the pins are registered. The ring, tone and retiming inputs pass through to det_o and irq_no in the same cycle, combined by the registered mode. For that reason each random vector is driven at a falling edge and checked 5 ns after the next rising edge. The carrier flag is checked on both sides of its boundary: once after ON_MS*TICK_DIV edges, counted from the first edge that samples the new level, when it must not yet have moved, and again one edge later, when it must have moved. The off delay is checked the same way. The clear on a mode change is checked at the first edge after the pins change.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    typedef enum logic [1:0] {
        MODE_TONE = 2'd0,
        MODE_FSK  = 2'd1,
        MODE_ZPWR = 2'd2
    } lmode_e;

    typedef enum logic [1:0] {
        QUAL_IDLE = 2'd0,
        QUAL_RISE = 2'd1,
        QUAL_ON   = 2'd2,
        QUAL_FALL = 2'd3
    } qual_state_e;

    function automatic lmode_e decode_mode(input logic zp, input logic sel);
        if (zp)
            return MODE_ZPWR;
        else if (sel)
            return MODE_FSK;
        else
            return MODE_TONE;
    endfunction

endpackage

// File: rtl/lmd_mode_fsm.sv
module lmd_mode_fsm
    import lmd_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   zp_i,
    input  logic   mode_sel_i,
    output lmode_e mode_q_o,
    output logic   mode_chg_o
);

    lmode_e state_q;
    lmode_e state_d;

    always_comb begin
        state_d = decode_mode(zp_i, mode_sel_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            state_q <= MODE_ZPWR;
        else
            state_q <= state_d;
    end

    always_comb begin
        mode_q_o   = state_q;
        mode_chg_o = 1'b0;
        unique case (state_q)
            MODE_TONE: mode_chg_o = (state_d != MODE_TONE);
            MODE_FSK:  mode_chg_o = (state_d != MODE_FSK);
            MODE_ZPWR: mode_chg_o = (state_d != MODE_ZPWR);
            default:   mode_chg_o = 1'b1;
        endcase
    end

    a_r1_zp_forces_zpwr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zp_i |=> (state_q == MODE_ZPWR));
    a_r1_fsk_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!zp_i && mode_sel_i) |=> (state_q == MODE_FSK));

endmodule

// File: rtl/lmd_ms_tick.sv
module lmd_ms_tick #(
    parameter int unsigned TICK_DIV = 3580
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic tick_o
);

    localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            pre_q <= '0;
        else if (restart_i || pre_q == PRE_LAST)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    assign tick_o = (pre_q == PRE_LAST);

    a_r7_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (TICK_DIV > 1 && tick_o) |=> !tick_o);

endmodule

// File: rtl/lmd_carrier_qual.sv
module lmd_carrier_qual
    import lmd_pkg::*;
#(
    parameter int unsigned ON_MS  = 25,
    parameter int unsigned OFF_MS = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic lvl_i,
    input  logic tick_i,
    output logic restart_o,
    output logic carrier_o
);

    localparam int unsigned MAX_MS = (ON_MS > OFF_MS) ? ON_MS : OFF_MS;
    localparam int unsigned CNT_W  = $clog2(MAX_MS + 1);
    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_MS - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_MS - 1);

    qual_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic timing;

    always_comb begin
        state_d   = state_q;
        restart_o = 1'b0;
        if (clear_i) begin
            state_d   = QUAL_IDLE;
            restart_o = 1'b1;
        end else begin
            unique case (state_q)
                QUAL_IDLE: if (lvl_i) begin
                    state_d   = QUAL_RISE;
                    restart_o = 1'b1;
                end
                QUAL_RISE: begin
                    if (!lvl_i)
                        state_d = QUAL_IDLE;
                    else if (tick_i && cnt_q == ON_LAST)
                        state_d = QUAL_ON;
                end
                QUAL_ON: if (!lvl_i) begin
                    state_d   = QUAL_FALL;
                    restart_o = 1'b1;
                end
                QUAL_FALL: begin
                    if (lvl_i)
                        state_d = QUAL_ON;
                    else if (tick_i && cnt_q == OFF_LAST)
                        state_d = QUAL_IDLE;
                end
                default: state_d = QUAL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            state_q <= QUAL_IDLE;
        else
            state_q <= state_d;
    end

    assign timing = (state_q == QUAL_RISE) || (state_q == QUAL_FALL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            cnt_q <= '0;
        else if (restart_o || !timing)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        unique case (state_q)
            QUAL_ON, QUAL_FALL: carrier_o = 1'b1;
            default:            carrier_o = 1'b0;
        endcase
    end

    a_r9_rise_needs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(carrier_o) |-> $past(lvl_i));
    a_r8_fall_needs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(carrier_o) && !$past(clear_i)) |-> !$past(lvl_i));
    a_r10_clear_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> !carrier_o);

endmodule

// File: rtl/lmd_out_router.sv
module lmd_out_router
    import lmd_pkg::*;
(
    input  lmode_e mode_i,
    input  logic   carrier_i,
    input  logic   ring_det_i,
    input  logic   ring_wake_en_i,
    input  logic   tone_det_i,
    input  logic   tone_irq_ni,
    input  logic   rt_irq_ni,
    output logic   det_o,
    output logic   irq_no,
    output logic   analog_en_o,
    output logic   osc_en_o,
    output logic   thr_sel_o
);

    always_comb begin
        det_o       = ring_det_i;
        irq_no      = !ring_det_i;
        analog_en_o = 1'b0;
        osc_en_o    = 1'b0;
        thr_sel_o   = 1'b0;
        unique case (mode_i)
            MODE_TONE: begin
                det_o       = tone_det_i;
                irq_no      = tone_irq_ni & !(ring_wake_en_i & ring_det_i);
                analog_en_o = 1'b1;
                osc_en_o    = 1'b1;
            end
            MODE_FSK: begin
                det_o       = carrier_i;
                irq_no      = rt_irq_ni & !ring_det_i;
                analog_en_o = 1'b1;
                osc_en_o    = 1'b1;
                thr_sel_o   = 1'b1;
            end
            default: begin
                det_o  = ring_det_i;
                irq_no = !ring_det_i;
            end
        endcase
    end

endmodule

// File: rtl/line_mode_detect.sv
module line_mode_detect
    import lmd_pkg::*;
#(
    parameter int unsigned TICK_DIV = 3580,
    parameter int unsigned ON_MS    = 25,
    parameter int unsigned OFF_MS   = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic zp_i,
    input  logic mode_sel_i,
    input  logic lvl_above_i,
    input  logic ring_det_i,
    input  logic ring_wake_en_i,
    input  logic tone_det_i,
    input  logic tone_irq_ni,
    input  logic rt_irq_ni,
    output logic det_o,
    output logic irq_no,
    output logic analog_en_o,
    output logic osc_en_o,
    output logic thr_sel_o
);

    lmode_e mode_q;
    logic   mode_chg;
    logic   qual_clear;
    logic   tick;
    logic   restart;
    logic   carrier;

    lmd_mode_fsm u_mode (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .zp_i       (zp_i),
        .mode_sel_i (mode_sel_i),
        .mode_q_o   (mode_q),
        .mode_chg_o (mode_chg)
    );

    assign qual_clear = mode_chg || (mode_q != MODE_FSK);

    lmd_ms_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .tick_o    (tick)
    );

    lmd_carrier_qual #(.ON_MS(ON_MS), .OFF_MS(OFF_MS)) u_qual (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (qual_clear),
        .lvl_i     (lvl_above_i),
        .tick_i    (tick),
        .restart_o (restart),
        .carrier_o (carrier)
    );

    lmd_out_router u_route (
        .mode_i         (mode_q),
        .carrier_i      (carrier),
        .ring_det_i     (ring_det_i),
        .ring_wake_en_i (ring_wake_en_i),
        .tone_det_i     (tone_det_i),
        .tone_irq_ni    (tone_irq_ni),
        .rt_irq_ni      (rt_irq_ni),
        .det_o          (det_o),
        .irq_no         (irq_no),
        .analog_en_o    (analog_en_o),
        .osc_en_o       (osc_en_o),
        .thr_sel_o      (thr_sel_o)
    );

    a_r5_zp_stops_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zp_i |=> (!osc_en_o && !analog_en_o));
    a_r6_thr_follows_fsk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!zp_i && mode_sel_i) |=> thr_sel_o);
    a_r4_zp_ring_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zp_i |=> (irq_no == !ring_det_i));
    a_r11_no_carrier_off_fsk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q != MODE_FSK) |-> !carrier);
    a_r10_mode_change_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_q != $past(mode_q)) |-> !carrier);

endmodule

// File: tb/line_mode_detect_bench.sv
`timescale 1ns/1ps
module line_mode_detect_bench;

    localparam int unsigned DIV  = 4;
    localparam int unsigned ONM  = 25;
    localparam int unsigned OFFM = 8;
    localparam int unsigned ON_EDGES  = ONM * DIV;
    localparam int unsigned OFF_EDGES = OFFM * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic zp = 1'b1, msel = 1'b0, lvl = 1'b0, ring = 1'b0, ren = 1'b0;
    logic tdet = 1'b0, tirq_n = 1'b1, rirq_n = 1'b1;
    logic det, irq_n, an_en, osc_en, thr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    line_mode_detect #(.TICK_DIV(DIV), .ON_MS(ONM), .OFF_MS(OFFM)) u_line_mode_detect (
        .clk_i(clk), .rst_ni(rst_n), .zp_i(zp), .mode_sel_i(msel),
        .lvl_above_i(lvl), .ring_det_i(ring), .ring_wake_en_i(ren),
        .tone_det_i(tdet), .tone_irq_ni(tirq_n), .rt_irq_ni(rirq_n),
        .det_o(det), .irq_no(irq_n), .analog_en_o(an_en),
        .osc_en_o(osc_en), .thr_sel_o(thr)
    );

    // expected {det, irq_n, analog_en, osc_en, thr_sel}
    function automatic logic [4:0] expect_out(logic z, logic s, logic rg, logic en,
                                              logic td, logic ti, logic ri, logic car);
        if (z)
            return {rg, !rg, 1'b0, 1'b0, 1'b0};
        else if (s)
            return {car, ri & !rg, 1'b1, 1'b1, 1'b1};
        else
            return {td, ti & !(en & rg), 1'b1, 1'b1, 1'b0};
    endfunction

    task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    function automatic logic [4:0] outs();
        return {det, irq_n, an_en, osc_en, thr};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] r;
        void'($urandom(32'd1957));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #5;
        // reset state: zero-power, ring idle (R1, R5)
        chk("R1 reset zero-power", outs(), 5'b01000);
        edges(2);
        // R4: zero-power ignores tone/retiming/level
        @(negedge clk) begin tdet = 1'b1; tirq_n = 1'b0; rirq_n = 1'b0; lvl = 1'b1; ring = 1'b1; end
        edges(1);
        chk("R4 zero-power ring route", outs(), 5'b10000);
        @(negedge clk) begin tdet = 1'b0; tirq_n = 1'b1; rirq_n = 1'b1; lvl = 1'b0; ring = 1'b0; end
        edges(1);

        // FSK mode, carrier rise timing (R7)
        @(negedge clk) begin zp = 1'b0; msel = 1'b1; end
        edges(3);
        chk("R6 FSK threshold", outs(), 5'b01111);
        @(negedge clk) lvl = 1'b1;
        edges(ON_EDGES);
        chk("R7 carrier not before on delay", {4'b0, det}, 5'b0);
        edges(1);
        chk("R7 carrier after on delay", {4'b0, det}, 5'b1);
        // short dip keeps carrier (R9)
        @(negedge clk) lvl = 1'b0;
        edges(OFF_EDGES - 2);
        @(negedge clk) lvl = 1'b1;
        edges(OFF_EDGES + 4);
        chk("R9 dip keeps carrier", {4'b0, det}, 5'b1);
        // fall timing (R8)
        @(negedge clk) lvl = 1'b0;
        edges(OFF_EDGES);
        chk("R8 carrier held during off delay", {4'b0, det}, 5'b1);
        edges(1);
        chk("R8 carrier after off delay", {4'b0, det}, 5'b0);
        // short pulse restarts rise (R9)
        @(negedge clk) lvl = 1'b1;
        edges(ON_EDGES - 10);
        @(negedge clk) lvl = 1'b0;
        @(negedge clk) lvl = 1'b1;
        edges(ON_EDGES);
        chk("R9 pulse restarts on delay", {4'b0, det}, 5'b0);
        edges(1);
        chk("R9 carrier after restarted delay", {4'b0, det}, 5'b1);
        // mode change drops carrier (R10, R11)
        @(negedge clk) msel = 1'b0;
        edges(1);
        chk("R10 mode change clears carrier", outs(), 5'b01110);
        @(negedge clk) msel = 1'b1;
        edges(ON_EDGES - 2);
        chk("R10 carrier needs full delay again", {4'b0, det}, 5'b0);
        edges(4);
        chk("R10 carrier requalified", {4'b0, det}, 5'b1);
        @(negedge clk) begin zp = 1'b1; end
        edges(1);
        chk("R11 zero-power drops carrier", outs(), 5'b01000);
        @(negedge clk) begin zp = 1'b0; end
        edges(1);
        chk("R11 back to FSK no carrier", {4'b0, det}, 5'b0);
        @(negedge clk) lvl = 1'b0;
        edges(2);

        // tone mode with ring wake enabled (R2)
        @(negedge clk) begin msel = 1'b0; ren = 1'b1; ring = 1'b1; end
        edges(1);
        chk("R2 tone ring wake", outs(), 5'b00110);
        @(negedge clk) begin ren = 1'b0; end
        edges(1);
        chk("R2 tone ring masked", outs(), 5'b01110);
        @(negedge clk) ring = 1'b0;
        edges(1);

        // random routing vectors, level held low so carrier stays 0 (R1..R6)
        for (int i = 0; i < 400; i++) begin
            @(negedge clk) begin
                r = 8'($urandom);
                zp = r[0] & r[1];
                msel = r[2]; ring = r[3]; ren = r[4];
                tdet = r[5]; tirq_n = r[6]; rirq_n = r[7];
            end
            edges(1);
            if (zp)
                chk("R4 random zero-power", outs(), expect_out(zp, msel, ring, ren, tdet, tirq_n, rirq_n, 1'b0));
            else if (msel)
                chk("R3 random FSK", outs(), expect_out(zp, msel, ring, ren, tdet, tirq_n, rirq_n, 1'b0));
            else
                chk("R2 random tone", outs(), expect_out(zp, msel, ring, ren, tdet, tirq_n, rirq_n, 1'b0));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule